// File: doc/BRIEF.md
# Scratchpad Block-Transfer Engine

This block is a per-core DMA engine that copies runs of words between a core's scratchpad (local memory) and system memory. Software sets it up with uncached stores to a small register window. It writes a source address, a destination address and a word count, and then a command code. Code 1 is a fetch, which reads from system memory and writes into the scratchpad. Code 2 is a flush, which reads from the scratchpad and writes to system memory.

Each system-memory access carries a coherence sideband. A fetch request asks the caches to supply the line if they hold it. A flush request tells every cache level to drop its copy. The engine also feeds a per-core buffer directory:
- When a fetch is accepted, the engine announces the scratchpad buffer base and the system address it now mirrors. This replaces whatever that buffer held before.
- When the last word of that fetch has landed, the engine raises a completion pulse carrying the buffer base.

Software waits for outstanding work in one of two ways. It can poll the busy flag, or it can raise a wait request that the engine answers with a stall for as long as a transfer is in flight.

Top module: `lm_dma_engine`

## Requirements
- R1: After reset, the status register reads zero, and no bus request, directory announcement or completion pulse is active.
- R2: A fetch of N words reads system memory at consecutive word addresses from the source and writes the scratchpad at consecutive word addresses from the destination, one word per accepted bus handshake. Its requests carry sm_lookup=1, sm_inval=0 and sm_we=0, and scratchpad words outside the range are untouched.
- R3: A flush of N words reads the scratchpad from the source and writes system memory from the destination, one word per accepted handshake. Its requests carry sm_we=1, sm_inval=1 and sm_lookup=0.
- R4: While sm_ack is low, sm_req stays high and sm_addr stays unchanged. After an accepted word that is not the last, the next request address is one higher.
- R5: In the cycle after a fetch command is accepted, dir_upd_valid is high for exactly one cycle, with dir_upd_lm equal to the destination and dir_upd_sm equal to the source. A flush produces no announcement.
- R6: In the cycle after the last word of a fetch is accepted, get_done is high for exactly one cycle, with get_done_lm equal to that fetch's destination. A flush produces no completion pulse.
- R7: A command written while a transfer is in flight is rejected. Status bit 1 (error) is set, and the running transfer continues unchanged to its correct result.
- R8: A command with a word count of zero, or with a code other than 1 or 2, sets status bit 1. It starts no request and produces no announcement.
- R9: Writing the status register with bit 1 set clears the error bit.
- R10: Status bit 0 is the busy flag. sync_stall equals sync_req while a transfer is in flight and is low otherwise.
- R11: The register offsets are 0 source, 1 destination, 2 word count (the low LEN_W bits are kept), 3 command and 4 status. Registers 0, 1 and 2 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmio_wr | input | 1 | Register write strobe |
| mmio_addr | input | 3 | Register word offset |
| mmio_wdata | input | 32 | Register write data |
| mmio_rdata | output | 32 | Read data of the register at mmio_addr (combinational) |
| sync_req | input | 1 | Software request to wait for completion |
| sync_stall | output | 1 | Stall held while a transfer is in flight |
| sm_req | output | 1 | System-memory request valid |
| sm_we | output | 1 | Request is a write |
| sm_lookup | output | 1 | Sideband: serve from caches when present |
| sm_inval | output | 1 | Sideband: invalidate the line in all caches |
| sm_addr | output | SM_AW | System-memory word address |
| sm_wdata | output | DW | System-memory write data |
| sm_ack | input | 1 | Handshake accepted; read data valid in the same cycle |
| sm_rdata | input | DW | System-memory read data |
| lm_we | output | 1 | Scratchpad write enable |
| lm_addr | output | LM_AW | Scratchpad word address |
| lm_wdata | output | DW | Scratchpad write data |
| lm_rdata | input | DW | Scratchpad read data (combinational read) |
| dir_upd_valid | output | 1 | Directory announcement for a fetch |
| dir_upd_lm | output | LM_AW | Buffer base being refilled |
| dir_upd_sm | output | SM_AW | System address the buffer now mirrors |
| get_done | output | 1 | Fetch completion pulse |
| get_done_lm | output | LM_AW | Buffer base of the completed fetch |

## Verification
A wrong pointer or a wrong word counter appears in the destination memory as soon as the transfer ends. It can show as a shifted copy, a short copy or an overwritten neighbour word, so the bench checks every copied word and the first word past the end. A stale direction flag shows at once on the coherence sideband of the first request. A broken busy or error state shows at the status register the cycle after the offending command write. The directory and completion pulses are checked for their count, their values and the exact cycle in which they appear.

// File: rtl/lm_dma_engine.sv
module lm_dma_engine #(
  parameter int SM_AW = 32,
  parameter int LM_AW = 12,
  parameter int LEN_W = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mmio_wr,
  input  logic [2:0]       mmio_addr,
  input  logic [31:0]      mmio_wdata,
  output logic [31:0]      mmio_rdata,
  input  logic             sync_req,
  output logic             sync_stall,
  output logic             sm_req,
  output logic             sm_we,
  output logic             sm_lookup,
  output logic             sm_inval,
  output logic [SM_AW-1:0] sm_addr,
  output logic [DW-1:0]    sm_wdata,
  input  logic             sm_ack,
  input  logic [DW-1:0]    sm_rdata,
  output logic             lm_we,
  output logic [LM_AW-1:0] lm_addr,
  output logic [DW-1:0]    lm_wdata,
  input  logic [DW-1:0]    lm_rdata,
  output logic             dir_upd_valid,
  output logic [LM_AW-1:0] dir_upd_lm,
  output logic [SM_AW-1:0] dir_upd_sm,
  output logic             get_done,
  output logic [LM_AW-1:0] get_done_lm
);
  localparam logic [2:0] A_SRC  = 3'd0;
  localparam logic [2:0] A_DST  = 3'd1;
  localparam logic [2:0] A_LEN  = 3'd2;
  localparam logic [2:0] A_CMD  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [31:0]      cfg_src, cfg_dst;
  logic [LEN_W-1:0] cfg_len, remain;
  logic [SM_AW-1:0] cur_sm;
  logic [LM_AW-1:0] cur_lm, buf_base;
  logic             busy, is_get, err, dir_q, done_q;

  wire cmd_hit = mmio_wr && (mmio_addr == A_CMD);
  wire cmd_get = (mmio_wdata == 32'd1);
  wire cmd_put = (mmio_wdata == 32'd2);
  wire cmd_ok  = !busy && (cfg_len != '0) && (cmd_get || cmd_put);
  wire beat    = busy && sm_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_src  <= '0;
      cfg_dst  <= '0;
      cfg_len  <= '0;
      remain   <= '0;
      cur_sm   <= '0;
      cur_lm   <= '0;
      buf_base <= '0;
      busy     <= 1'b0;
      is_get   <= 1'b0;
      err      <= 1'b0;
      dir_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      if (mmio_wr) begin
        case (mmio_addr)
          A_SRC:   cfg_src <= mmio_wdata;
          A_DST:   cfg_dst <= mmio_wdata;
          A_LEN:   cfg_len <= mmio_wdata[LEN_W-1:0];
          A_STAT:  if (mmio_wdata[1]) err <= 1'b0;
          default: ;
        endcase
      end
      if (cmd_hit) begin
        if (cmd_ok) begin
          busy     <= 1'b1;
          is_get   <= cmd_get;
          remain   <= cfg_len;
          cur_sm   <= cmd_get ? cfg_src[SM_AW-1:0] : cfg_dst[SM_AW-1:0];
          cur_lm   <= cmd_get ? cfg_dst[LM_AW-1:0] : cfg_src[LM_AW-1:0];
          buf_base <= cfg_dst[LM_AW-1:0];
          dir_q    <= cmd_get;
        end else begin
          err <= 1'b1;
        end
      end
      if (beat) begin
        cur_sm <= cur_sm + 1'b1;
        cur_lm <= cur_lm + 1'b1;
        remain <= remain - ONE;
        if (remain == ONE) begin
          busy   <= 1'b0;
          done_q <= is_get;
        end
      end
    end
  end

  always_comb begin
    case (mmio_addr)
      A_SRC:   mmio_rdata = cfg_src;
      A_DST:   mmio_rdata = cfg_dst;
      A_LEN:   mmio_rdata = 32'(cfg_len);
      A_STAT:  mmio_rdata = {30'd0, err, busy};
      default: mmio_rdata = '0;
    endcase
  end

  assign sync_stall    = sync_req && busy;
  assign sm_req        = busy;
  assign sm_we         = busy && !is_get;
  assign sm_lookup     = busy && is_get;
  assign sm_inval      = busy && !is_get;
  assign sm_addr       = cur_sm;
  assign sm_wdata      = lm_rdata;
  assign lm_addr       = cur_lm;
  assign lm_we         = beat && is_get;
  assign lm_wdata      = sm_rdata;
  assign dir_upd_valid = dir_q;
  assign dir_upd_lm    = cur_lm;
  assign dir_upd_sm    = cur_sm;
  assign get_done      = done_q;
  assign get_done_lm   = buf_base;
endmodule

// File: rtl/lm_dma_engine_chk.sv
module lm_dma_engine_chk #(
  parameter int SM_AW = 32,
  parameter int LM_AW = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_stall,
  input logic             sm_req,
  input logic             sm_we,
  input logic             sm_lookup,
  input logic             sm_inval,
  input logic [SM_AW-1:0] sm_addr,
  input logic             sm_ack,
  input logic             lm_we,
  input logic             dir_upd_valid,
  input logic             get_done
);
  AST_FETCH_SIDEBAND: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_req && !sm_we) |-> (sm_lookup && !sm_inval)); // R2
  AST_LM_WRITE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    lm_we |-> (sm_req && sm_ack && !sm_we)); // R2
  AST_FLUSH_SIDEBAND: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_req && sm_we) |-> (sm_inval && !sm_lookup)); // R3
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_req && !sm_ack) |=> (sm_req && $stable(sm_addr))); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_req && sm_ack) |=> (!sm_req || (sm_addr == $past(sm_addr) + 1'b1))); // R4
  AST_DIR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sm_req) && !sm_we) |-> dir_upd_valid); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    get_done |=> !get_done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    get_done |-> !sm_req); // R6
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_stall |-> sm_req); // R10
endmodule

bind lm_dma_engine lm_dma_engine_chk #(.SM_AW(SM_AW), .LM_AW(LM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_stall(sync_stall), .sm_req(sm_req),
  .sm_we(sm_we), .sm_lookup(sm_lookup), .sm_inval(sm_inval),
  .sm_addr(sm_addr), .sm_ack(sm_ack), .lm_we(lm_we),
  .dir_upd_valid(dir_upd_valid), .get_done(get_done)
);

// File: tb/lm_dma_engine_test.sv
`timescale 1ns/1ps
module lm_dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmio_wr = 1'b0;
  logic [2:0]  mmio_addr = 3'd0;
  logic [31:0] mmio_wdata = 32'd0;
  logic [31:0] mmio_rdata;
  logic        sync_req = 1'b0;
  logic        sync_stall;
  logic        sm_req, sm_we, sm_lookup, sm_inval;
  logic [31:0] sm_addr, sm_wdata, sm_rdata;
  logic        sm_ack = 1'b0;
  logic        lm_we;
  logic [11:0] lm_addr;
  logic [31:0] lm_wdata, lm_rdata;
  logic        dir_upd_valid, get_done;
  logic [11:0] dir_upd_lm, get_done_lm;
  logic [31:0] dir_upd_sm;

  logic [31:0] sm_mem [256];
  logic [31:0] lm_mem [256];
  logic        init_req = 1'b0;
  logic        ack_hold = 1'b0;
  logic        ack_mode = 1'b0;
  int checks = 0, failures = 0;
  int dir_cnt = 0, done_cnt = 0, proto_err = 0;
  logic [11:0] dir_lm_last, done_lm_last;
  logic [31:0] dir_sm_last;

  always #4 clk = ~clk;

  lm_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .mmio_wr(mmio_wr), .mmio_addr(mmio_addr),
    .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata), .sync_req(sync_req),
    .sync_stall(sync_stall), .sm_req(sm_req), .sm_we(sm_we),
    .sm_lookup(sm_lookup), .sm_inval(sm_inval), .sm_addr(sm_addr),
    .sm_wdata(sm_wdata), .sm_ack(sm_ack), .sm_rdata(sm_rdata),
    .lm_we(lm_we), .lm_addr(lm_addr), .lm_wdata(lm_wdata), .lm_rdata(lm_rdata),
    .dir_upd_valid(dir_upd_valid), .dir_upd_lm(dir_upd_lm),
    .dir_upd_sm(dir_upd_sm), .get_done(get_done), .get_done_lm(get_done_lm)
  );

  function automatic logic [31:0] sm_pat(input int i);
    return 32'hC0DE0000 | 32'(i * 3);
  endfunction
  function automatic logic [31:0] lm_pat(input int i);
    return 32'h5A000000 | 32'(i * 7);
  endfunction

  assign sm_rdata = sm_mem[sm_addr[7:0]];
  assign lm_rdata = lm_mem[lm_addr[7:0]];

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) begin
        sm_mem[i] <= sm_pat(i);
        lm_mem[i] <= lm_pat(i);
      end
    end else begin
      if (sm_req && sm_ack && sm_we) sm_mem[sm_addr[7:0]] <= sm_wdata;
      if (lm_we) lm_mem[lm_addr[7:0]] <= lm_wdata;
    end
  end

  always @(negedge clk) sm_ack <= ack_hold ? 1'b0 : (ack_mode ? ~sm_ack : 1'b1);

  always @(negedge clk) begin
    if (rst_n) begin
      if (dir_upd_valid) begin
        dir_cnt++; dir_lm_last = dir_upd_lm; dir_sm_last = dir_upd_sm;
      end
      if (get_done) begin
        done_cnt++; done_lm_last = get_done_lm;
      end
      if (sm_req && sm_we && (!sm_inval || sm_lookup)) proto_err++;
      if (sm_req && !sm_we && (!sm_lookup || sm_inval)) proto_err++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    mmio_wr = 1'b1; mmio_addr = a; mmio_wdata = d;
    @(negedge clk);
    mmio_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    mmio_addr = a;
    #1 d = mmio_rdata;
  endtask

  task automatic init_mems();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(3'd4, s);
      if (!s[0]) break;
    end
    @(negedge clk);
  endtask

  // {op[1:0], src[7:0], dst[7:0], len[7:0], toggling_ack}
  localparam logic [26:0] VEC [6] = '{
    {2'd1, 8'd10,  8'd0,   8'd4,  1'b0},
    {2'd1, 8'd40,  8'd20,  8'd1,  1'b1},
    {2'd2, 8'd20,  8'd80,  8'd5,  1'b0},
    {2'd2, 8'd3,   8'd100, 8'd8,  1'b1},
    {2'd1, 8'd200, 8'd64,  8'd16, 1'b1},
    {2'd2, 8'd64,  8'd150, 8'd2,  1'b0}
  };

  initial begin
    logic [31:0] s, a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd(3'd4, s);
    chk(s == 32'd0, "R1 status after reset", s, 32'd0);
    chk(!sm_req && !dir_upd_valid && !get_done, "R1 outputs idle after reset",
        {29'd0, sm_req, dir_upd_valid, get_done}, 32'd0);

    wr(3'd0, 32'h12345678); wr(3'd1, 32'h0000ABCD); wr(3'd2, 32'h00010005);
    rd(3'd0, s); chk(s == 32'h12345678, "R11 source readback", s, 32'h12345678);
    rd(3'd1, s); chk(s == 32'h0000ABCD, "R11 destination readback", s, 32'h0000ABCD);
    rd(3'd2, s); chk(s == 32'd5, "R11 count readback truncated", s, 32'd5);

    for (int v = 0; v < 6; v++) begin
      logic [1:0] op;
      int src, dst, len, mism, d0, n0;
      logic [31:0] got, exp, edge_exp;
      op = VEC[v][26:25]; src = int'(VEC[v][24:17]); dst = int'(VEC[v][16:9]);
      len = int'(VEC[v][8:1]);
      init_mems();
      ack_mode = VEC[v][0];
      wr(3'd0, 32'(src)); wr(3'd1, 32'(dst)); wr(3'd2, 32'(len));
      d0 = dir_cnt; n0 = done_cnt;
      wr(3'd3, 32'(op));
      wait_idle();
      mism = 0;
      for (int k = 0; k < len; k++) begin
        got = (op == 2'd1) ? lm_mem[dst + k] : sm_mem[dst + k];
        exp = (op == 2'd1) ? sm_pat(src + k) : lm_pat(src + k);
        if (got != exp) mism++;
      end
      got = (op == 2'd1) ? lm_mem[dst + len] : sm_mem[dst + len];
      edge_exp = (op == 2'd1) ? lm_pat(dst + len) : sm_pat(dst + len);
      if (op == 2'd1) begin
        chk(mism == 0, "R2 fetched words", 32'(mism), 32'd0);
        chk(got == edge_exp, "R2 word past fetch end untouched", got, edge_exp);
        chk(dir_cnt - d0 == 1 && dir_lm_last == 12'(dst) && dir_sm_last == 32'(src),
            "R5 directory announcement", {dir_lm_last, 20'(dir_sm_last)}, {12'(dst), 20'(src)});
        chk(done_cnt - n0 == 1 && done_lm_last == 12'(dst), "R6 completion pulse",
            32'(done_lm_last), 32'(dst));
      end else begin
        chk(mism == 0, "R3 flushed words", 32'(mism), 32'd0);
        chk(got == edge_exp, "R3 word past flush end untouched", got, edge_exp);
        chk(dir_cnt == d0, "R5 no announcement on flush", 32'(dir_cnt - d0), 32'd0);
        chk(done_cnt == n0, "R6 no completion on flush", 32'(done_cnt - n0), 32'd0);
      end
    end
    chk(proto_err == 0, "R2 R3 coherence sideband", 32'(proto_err), 32'd0);

    begin
      int d0;
      init_mems();
      ack_mode = 1'b0; ack_hold = 1'b1;
      wr(3'd0, 32'd5); wr(3'd1, 32'd30); wr(3'd2, 32'd3);
      d0 = dir_cnt;
      wr(3'd3, 32'd1);
      #1;
      chk(dir_upd_valid && dir_upd_lm == 12'd30 && dir_upd_sm == 32'd5,
          "R5 announcement in cycle after command", {20'd0, dir_upd_lm}, 32'd30);
      a0 = sm_addr;
      sync_req = 1'b1;
      #1 chk(sync_stall, "R10 stall while busy", {31'd0, sync_stall}, 32'd1);
      wr(3'd3, 32'd2);
      rd(3'd4, s);
      chk(s == 32'd3, "R7 busy and error after rejected command", s, 32'd3);
      chk(sm_addr == a0 && sm_req, "R4 request held without ack", sm_addr, a0);
      ack_hold = 1'b0;
      wait_idle();
      #1 chk(!sync_stall, "R10 stall released when idle", {31'd0, sync_stall}, 32'd0);
      sync_req = 1'b0;
      chk(lm_mem[30] == sm_pat(5) && lm_mem[31] == sm_pat(6) && lm_mem[32] == sm_pat(7),
          "R7 running fetch unaffected", lm_mem[32], sm_pat(7));
      chk(dir_cnt - d0 == 1, "R7 rejected command made no announcement", 32'(dir_cnt - d0), 32'd1);
      wr(3'd4, 32'd2);
      rd(3'd4, s);
      chk(s == 32'd0, "R9 error cleared", s, 32'd0);
    end

    begin
      int d0;
      d0 = dir_cnt;
      wr(3'd2, 32'd0);
      wr(3'd3, 32'd1);
      rd(3'd4, s);
      chk(s == 32'd2, "R8 zero count rejected", s, 32'd2);
      chk(!sm_req, "R8 zero count starts no request", {31'd0, sm_req}, 32'd0);
      wr(3'd4, 32'd2);
      wr(3'd2, 32'd4);
      wr(3'd3, 32'd3);
      rd(3'd4, s);
      chk(s == 32'd2, "R8 unknown code rejected", s, 32'd2);
      @(negedge clk); #1;
      chk(!sm_req && dir_cnt == d0, "R8 no request or announcement",
          {31'd0, sm_req}, 32'd0);
      wr(3'd4, 32'd2);
      rd(3'd4, s);
      chk(s == 32'd0, "R9 error cleared again", s, 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule